// File: doc/BRIEF.md
# Processor Status Register with Flag Arbitration

This block holds the eight-bit status word of a small accumulator-style microcontroller core. The word carries three arithmetic flags (zero, digit carry, carry), two power-management flags (time-out, power-down) and three bank-select bits. The lowest bank-select bit chooses the 128-byte half of data memory used by direct addressing. It is also brought out on its own pin.

Three sources can change the word in one clock. The first is a register-file write whose address decodes to the status location. The second is an ALU flag update with an enable per flag. The third is a set of event strobes from the watchdog and the instruction decoder: watchdog clear, sleep entry and watchdog time-out. A fixed arbitration decides the result. ALU-driven flags override written data. The power flags follow events only. A time-out beats a watchdog clear. All updates land on the rising clock edge, and power-on is a synchronous active-high reset.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the word becomes 8'h18: bank bits 0, time-out 1, power-down 1, and the three ALU flags 0 (default reset option). Reset beats every other input.
- R2: Bit positions in `status_q`, MSB to LSB, are: indirect bank bit, upper bank bit, bank bit, time-out, power-down, zero, digit carry, carry. `bank_sel` always equals bit 5.
- R3: A write that hits the status address with all ALU flag enables low loads bits 7:5 and 2:0 from `wr_data` after the next rising edge.
- R4: A write hits when the low 7 address bits equal 7'h03 in either bank (8'h03 or 8'h83). Any other address leaves the word unchanged.
- R5: If a write hit comes with any ALU flag enable set, data bits 2:0 are discarded. Each enabled flag takes its ALU value and each non-enabled flag holds. Bits 7:5 still load from data.
- R6: With no write, each flag whose enable is set takes its ALU value (`alu_flag_we`/`alu_flags` bit 2 = zero, 1 = digit carry, 0 = carry), and the others hold.
- R7: Time-out and power-down never change through a data write. They hold unless an event strobe is present.
- R8: A watchdog clear alone sets both time-out and power-down.
- R9: A sleep strobe without a time-out sets time-out and clears power-down.
- R10: A watchdog time-out clears time-out and wins over a same-cycle clear or sleep. A time-out alone leaves power-down unchanged.
- R11: Clear and sleep together give time-out 1 and power-down 0.
- R12: A clear-register instruction on the status word is presented as data 0 with only the zero-flag enable set and a zero-flag value of 1. It yields 000u u1uu: the upper three bits clear, zero sets, and time-out, power-down, digit carry and carry keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all updates on rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | ADDR_W (8) | Register-file write address |
| wr_data | input | 8 | Register-file write data |
| alu_flag_we | input | 3 | Per-flag update enables {zero, digit carry, carry} |
| alu_flags | input | 3 | ALU flag results {zero, digit carry, carry} |
| evt_clrwdt | input | 1 | Watchdog-clear instruction strobe |
| evt_sleep | input | 1 | Sleep instruction strobe |
| evt_wdt_timeout | input | 1 | Watchdog time-out strobe |
| status_q | output | 8 | Current status word |
| bank_sel | output | 1 | Direct-addressing bank select |

## Verification
The flag assertions assume that a flag enable is one-cycle information tied to the current instruction. Each is compared with the flag value captured in the same cycle. The power-flag assertions assume that event strobes may coincide in any combination. They are therefore written per combination, not on a single-strobe basis. The stimulus changes inputs only at falling edges and returns them to idle after each cycle. It covers every strobe pair that has its own priority rule, as well as writes that overlap flag updates. All checks run under the default parameters: mirrored address decode, writable reserved bank bits and reset ALU flags.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

   localparam int unsigned STAT_W   = 8;
   localparam int unsigned NFLAG    = 3;

   // bit positions; the decoder and bank logic depend on these
   localparam int unsigned POS_C    = 0;
   localparam int unsigned POS_DC   = 1;
   localparam int unsigned POS_Z    = 2;
   localparam int unsigned POS_PD   = 3;
   localparam int unsigned POS_TO   = 4;
   localparam int unsigned POS_BK0  = 5;
   localparam int unsigned POS_BK1  = 6;
   localparam int unsigned POS_IBK  = 7;

   typedef struct packed {
      logic ibk;
      logic bk1;
      logic bk0;
      logic to;
      logic pd;
      logic z;
      logic dc;
      logic c;
   } status_word_t;

endpackage

// File: rtl/status_addr_match.sv
module status_addr_match #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned OFS_W      = 7,
   parameter int unsigned STATUS_OFS = 3,
   parameter bit          MIRROR     = 1'b1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit
);

   localparam logic [OFS_W-1:0]  OFS_VAL  = OFS_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] FULL_VAL = ADDR_W'(STATUS_OFS);

   generate
      if (MIRROR) begin : g_mirror
         logic unused_bank_addr;
         assign unused_bank_addr = ^wr_addr[ADDR_W-1:OFS_W];
         assign hit = wr_en && (wr_addr[OFS_W-1:0] == OFS_VAL);
      end else begin : g_single
         assign hit = wr_en && (wr_addr == FULL_VAL);
      end
   endgenerate

endmodule

// File: rtl/status_alu_flags.sv
module status_alu_flags #(
   parameter int unsigned          NFLAG      = 3,
   parameter bit                   RESET_EN   = 1'b1,
   parameter logic [NFLAG-1:0]     INIT       = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             data_hit,
   input  logic [NFLAG-1:0] data_bits,
   input  logic [NFLAG-1:0] flag_we,
   input  logic [NFLAG-1:0] flag_val,
   output logic [NFLAG-1:0] flag_q
);

   logic             any_we;
   logic [NFLAG-1:0] flag_d;

   assign any_we = |flag_we;

   // per-flag arbitration: ALU first, then unblocked data, else hold
   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_bit
         always_comb begin
            if (flag_we[i])
               flag_d[i] = flag_val[i];
            else if (data_hit && !any_we)
               flag_d[i] = data_bits[i];
            else
               flag_d[i] = flag_q[i];
         end
      end

      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst) flag_q <= INIT;
            else     flag_q <= flag_d;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst;
         always_ff @(posedge clk) flag_q <= flag_d;
      end
   endgenerate

endmodule

// File: rtl/status_power_flags.sv
module status_power_flags (
   input  logic clk,
   input  logic rst,
   input  logic evt_clrwdt,
   input  logic evt_sleep,
   input  logic evt_wdt_timeout,
   output logic to_q,
   output logic pd_q
);

   logic to_d;
   logic pd_d;

   always_comb begin
      // time-out: watchdog expiry has priority over any set source
      if (evt_wdt_timeout)               to_d = 1'b0;
      else if (evt_clrwdt || evt_sleep)  to_d = 1'b1;
      else                               to_d = to_q;
      // power-down: sleep wins over a same-cycle clear
      if (evt_sleep)                     pd_d = 1'b0;
      else if (evt_clrwdt)               pd_d = 1'b1;
      else                               pd_d = pd_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else begin
         to_q <= to_d;
         pd_q <= pd_d;
      end
   end

endmodule

// File: rtl/status_bank_bits.sv
module status_bank_bits #(
   parameter bit RESERVED_ZERO = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       data_hit,
   input  logic [2:0] data_bits,
   output logic [2:0] bank_q
);

   logic bk0_q;

   always_ff @(posedge clk) begin
      if (rst)           bk0_q <= 1'b0;
      else if (data_hit) bk0_q <= data_bits[0];
   end

   generate
      if (RESERVED_ZERO) begin : g_fixed
         logic unused_hi;
         assign unused_hi = ^data_bits[2:1];
         assign bank_q = {2'b00, bk0_q};
      end else begin : g_rw
         logic [1:0] hi_q;
         always_ff @(posedge clk) begin
            if (rst)           hi_q <= 2'b00;
            else if (data_hit) hi_q <= data_bits[2:1];
         end
         assign bank_q = {hi_q, bk0_q};
      end
   endgenerate

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned BANK_OFS_W     = 7,
   parameter int unsigned STATUS_OFS     = 3,
   parameter bit          MIRROR_BANKS   = 1'b1,
   parameter bit          RESERVED_ZERO  = 1'b0,
   parameter bit          RESET_ALU      = 1'b1,
   parameter logic [2:0]  ALU_INIT       = 3'b000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [2:0]        alu_flag_we,
   input  logic [2:0]        alu_flags,
   input  logic              evt_clrwdt,
   input  logic              evt_sleep,
   input  logic              evt_wdt_timeout,
   output logic [7:0]        status_q,
   output logic              bank_sel
);

   import cpu_status_pkg::*;

   localparam int unsigned OFS_SPAN = 1 << BANK_OFS_W;

   generate
      if (BANK_OFS_W >= ADDR_W) begin : g_err_w
         $error("ADDR_W must be wider than BANK_OFS_W");
      end
      if (STATUS_OFS >= OFS_SPAN) begin : g_err_ofs
         $error("STATUS_OFS outside one bank");
      end
      if (STAT_W != 8) begin : g_err_stat
         $error("status word must be 8 bits");
      end
   endgenerate

   logic         hit;
   logic [2:0]   flag_q;
   logic [2:0]   bank_q;
   logic         to_q;
   logic         pd_q;
   status_word_t word;

   status_addr_match #(
      .ADDR_W     (ADDR_W),
      .OFS_W      (BANK_OFS_W),
      .STATUS_OFS (STATUS_OFS),
      .MIRROR     (MIRROR_BANKS)
   ) u_match (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .hit     (hit)
   );

   status_alu_flags #(
      .NFLAG    (NFLAG),
      .RESET_EN (RESET_ALU),
      .INIT     (ALU_INIT)
   ) u_flags (
      .clk       (clk),
      .rst       (rst),
      .data_hit  (hit),
      .data_bits (wr_data[POS_Z:POS_C]),
      .flag_we   (alu_flag_we),
      .flag_val  (alu_flags),
      .flag_q    (flag_q)
   );

   status_power_flags u_power (
      .clk             (clk),
      .rst             (rst),
      .evt_clrwdt      (evt_clrwdt),
      .evt_sleep       (evt_sleep),
      .evt_wdt_timeout (evt_wdt_timeout),
      .to_q            (to_q),
      .pd_q            (pd_q)
   );

   status_bank_bits #(
      .RESERVED_ZERO (RESERVED_ZERO)
   ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .data_hit  (hit),
      .data_bits (wr_data[POS_IBK:POS_BK0]),
      .bank_q    (bank_q)
   );

   logic unused_pw;
   assign unused_pw = ^wr_data[POS_TO:POS_PD];

   always_comb begin
      word     = '0;
      word.ibk = bank_q[2];
      word.bk1 = bank_q[1];
      word.bk0 = bank_q[0];
      word.to  = to_q;
      word.pd  = pd_q;
      word.z   = flag_q[2];
      word.dc  = flag_q[1];
      word.c   = flag_q[0];
   end

   assign status_q = word;
   assign bank_sel = status_q[POS_BK0];

endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk #(
   parameter int unsigned OFS_W = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [OFS_W-1:0] wr_ofs,
   input logic             data_bk0,
   input logic [2:0]       data_lo,
   input logic [2:0]       alu_flag_we,
   input logic [2:0]       alu_flags,
   input logic             evt_clrwdt,
   input logic             evt_sleep,
   input logic             evt_wdt_timeout,
   input logic [7:0]       status_q,
   input logic             bank_sel
);

   logic hit_c;
   assign hit_c = wr_en && (wr_ofs == OFS_W'(3));

   assert_power_on_R1: assert property (@(posedge clk)
      rst |=> status_q[7:3] == 5'b00011);

   assert_bank_pin_R2: assert property (@(posedge clk) disable iff (rst)
      hit_c |=> bank_sel == $past(data_bk0));

   assert_data_flags_R3: assert property (@(posedge clk) disable iff (rst)
      hit_c && alu_flag_we == 3'b000 |=> status_q[2:0] == $past(data_lo));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !wr_en && alu_flag_we == 3'b000 |=> $stable(status_q[2:0]) && $stable(status_q[7:5]));

   assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
      alu_flag_we[2] |=> status_q[2] == $past(alu_flags[2]));

   assert_dcarry_R6: assert property (@(posedge clk) disable iff (rst)
      alu_flag_we[1] |=> status_q[1] == $past(alu_flags[1]));

   assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
      alu_flag_we[0] |=> status_q[0] == $past(alu_flags[0]));

   assert_power_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !(evt_clrwdt || evt_sleep || evt_wdt_timeout) |=> $stable(status_q[4:3]));

   assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      evt_clrwdt && !evt_sleep && !evt_wdt_timeout |=> status_q[4:3] == 2'b11);

   assert_sleep_R9: assert property (@(posedge clk) disable iff (rst)
      evt_sleep && !evt_wdt_timeout |=> status_q[4:3] == 2'b10);

   assert_timeout_R10: assert property (@(posedge clk) disable iff (rst)
      evt_wdt_timeout |=> !status_q[4]);

   assert_clr_sleep_R11: assert property (@(posedge clk) disable iff (rst)
      evt_clrwdt && evt_sleep |=> !status_q[3]);

endmodule

bind cpu_status_reg cpu_status_reg_chk #(.OFS_W(BANK_OFS_W)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .wr_en           (wr_en),
   .wr_ofs          (wr_addr[BANK_OFS_W-1:0]),
   .data_bk0        (wr_data[5]),
   .data_lo         (wr_data[2:0]),
   .alu_flag_we     (alu_flag_we),
   .alu_flags       (alu_flags),
   .evt_clrwdt      (evt_clrwdt),
   .evt_sleep       (evt_sleep),
   .evt_wdt_timeout (evt_wdt_timeout),
   .status_q        (status_q),
   .bank_sel        (bank_sel)
);

// File: tb/sim_cpu_status_reg.sv
module sim_cpu_status_reg;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] alu_flag_we = '0;
   logic [2:0] alu_flags = '0;
   logic       evt_clrwdt = 1'b0;
   logic       evt_sleep = 1'b0;
   logic       evt_wdt_timeout = 1'b0;
   logic [7:0] status_q;
   logic       bank_sel;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cpu_status_reg u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .alu_flag_we(alu_flag_we), .alu_flags(alu_flags), .evt_clrwdt(evt_clrwdt),
      .evt_sleep(evt_sleep), .evt_wdt_timeout(evt_wdt_timeout),
      .status_q(status_q), .bank_sel(bank_sel)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // drive for one rising edge starting at a falling edge, then return to idle
   task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic [2:0] fwe, input logic [2:0] fv,
                       input logic c, input logic s, input logic t);
      wr_en = we; wr_addr = a; wr_data = d; alu_flag_we = fwe; alu_flags = fv;
      evt_clrwdt = c; evt_sleep = s; evt_wdt_timeout = t;
      @(negedge clk);
      wr_en = 1'b0; alu_flag_we = '0; evt_clrwdt = 1'b0; evt_sleep = 1'b0;
      evt_wdt_timeout = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R1 reset word", status_q, 8'h18);
      check("R2 reset bank_sel", {7'd0, bank_sel}, 8'h00);
      rst = 1'b0;
   endtask

   task automatic t_data_write;
      step(1, 8'h03, 8'h20, 3'b000, 3'b000, 0, 0, 0);
      check("R2 bank bit position", status_q, 8'h38);
      check("R2 bank_sel set", {7'd0, bank_sel}, 8'h01);
      step(1, 8'h03, 8'hC0, 3'b000, 3'b000, 0, 0, 0);
      check("R2 upper bank bits", status_q, 8'hD8);
      check("R2 bank_sel clear", {7'd0, bank_sel}, 8'h00);
      step(1, 8'h03, 8'h00, 3'b000, 3'b000, 0, 0, 0);
      check("R7 data zero keeps power flags", status_q, 8'h18);
      step(1, 8'h03, 8'hE7, 3'b000, 3'b000, 0, 0, 0);
      check("R3 data write loads bits", status_q, 8'hFF);
   endtask

   task automatic t_addr_and_power_write;
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 0, 1, 0);
      check("R9 sleep", status_q, 8'hF7);
      step(1, 8'h83, 8'h00, 3'b000, 3'b000, 0, 0, 0);
      check("R4 mirror address hit", status_q, 8'h10);
      step(1, 8'h03, 8'hFF, 3'b000, 3'b000, 0, 0, 0);
      check("R7 data cannot set power-down", status_q, 8'hF7);
      step(1, 8'h04, 8'h00, 3'b000, 3'b000, 0, 0, 0);
      check("R4 miss 04h", status_q, 8'hF7);
      step(1, 8'h13, 8'h00, 3'b000, 3'b000, 0, 0, 0);
      check("R4 miss 13h", status_q, 8'hF7);
   endtask

   task automatic t_events;
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 1, 0, 0);
      check("R8 watchdog clear", status_q, 8'hFF);
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 0, 0, 1);
      check("R10 time-out alone", status_q, 8'hEF);
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 1, 0, 0);
      check("R8 clear after time-out", status_q, 8'hFF);
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 1, 0, 1);
      check("R10 time-out beats clear", status_q, 8'hEF);
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 1, 1, 0);
      check("R11 clear with sleep", status_q, 8'hF7);
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 0, 1, 1);
      check("R10 time-out beats sleep", status_q, 8'hE7);
   endtask

   task automatic t_alu_flags;
      step(0, 8'h00, 8'h00, 3'b111, 3'b000, 0, 0, 0);
      check("R6 all flags cleared", status_q, 8'hE0);
      step(0, 8'h00, 8'h00, 3'b101, 3'b111, 0, 0, 0);
      check("R6 zero and carry only", status_q, 8'hE5);
      step(0, 8'h00, 8'h00, 3'b010, 3'b010, 0, 0, 0);
      check("R6 digit carry only", status_q, 8'hE7);
      step(0, 8'h00, 8'h00, 3'b100, 3'b000, 0, 0, 0);
      check("R6 zero cleared alone", status_q, 8'hE3);
   endtask

   task automatic t_write_vs_alu;
      step(1, 8'h03, 8'h1C, 3'b001, 3'b000, 0, 0, 0);
      check("R5 data flags blocked", status_q, 8'h02);
      check("R5 bank_sel from data", {7'd0, bank_sel}, 8'h00);
   endtask

   task automatic t_clear_reg;
      step(0, 8'h00, 8'h00, 3'b000, 3'b000, 1, 0, 0);
      step(1, 8'h03, 8'hE1, 3'b000, 3'b000, 0, 0, 0);
      check("R3 setup before clear", status_q, 8'hF9);
      step(1, 8'h03, 8'h00, 3'b100, 3'b100, 0, 0, 0);
      check("R12 clear-register result", status_q, 8'h1D);
   endtask

   task automatic t_reset_priority;
      rst = 1'b1;
      step(1, 8'h03, 8'hFF, 3'b111, 3'b111, 0, 1, 1);
      rst = 1'b0;
      check("R1 reset beats events", status_q, 8'h18);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_data_write();
      t_addr_and_power_write();
      t_events();
      t_alu_flags();
      t_write_vs_alu();
      t_clear_reg();
      t_reset_priority();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule